// File: doc/BRIEF.md
# Strap-Selected Flash Boot Loader

This block runs once after the active-low reset is released. On the first clock edge after release it reads two strap pins and selects one of three boot modes. Two of them, debug-port mode and external-upload mode, are served by other logic, so the loader stays idle in both. In flash mode the loader opens a read on an external SPI flash and pulls in a fixed 512-byte image. It writes that image into instruction memory as 256 sixteen-bit words, then pulses a start signal to the core.

The instruction-memory write port is a valid/ready stream. The loader raises `pm_valid` with a stable address and word and keeps them unchanged until `pm_ready` is seen high on a clock edge. Only that edge counts as a transfer. While the memory side holds back, the SPI clock is frozen, so no flash bit is lost and the word in flight is not overwritten. The write address acts as the program counter. When it wraps from 255 back to 0 the load is over, the flash is deselected and the core is told to run from address 0.

Top module: `boot_flash_loader`

## Requirements
- R1: The straps are captured once, on the first rising clock edge after `rst_n` goes high. Strap changes after that edge do not change `boot_mode` or the loader's behaviour.
- R2: `boot_mode` is 2'b11 until the straps are captured. After capture it is 2'b10 when `strap_rw` is high, 2'b00 when `strap_rw` and `strap_ck` are both low, and 2'b01 when `strap_rw` is low and `strap_ck` is high.
- R3: `spi_cs_n` is high during reset, before capture, in modes 2'b00 and 2'b01, and after the load ends. It is low only while a load is in progress, and `pm_valid` is never high while it is high.
- R4: After chip select falls, the first 32 bits on `spi_mosi` are the read opcode 0x03 followed by a 24-bit address of zero, most significant bit first. MOSI changes only while SCK is low (SPI mode 0).
- R5: SCK idles low and, while running, has a period of `SPI_DIV` clock cycles. MISO is sampled on each rising SCK edge.
- R6: Each word is built from 16 consecutive data bits. The first bit received becomes bit 15, so the high byte arrives first, MSB first.
- R7: A word is transferred on a clock edge where `pm_valid` and `pm_ready` are both high. Addresses run 0,1,...,255 in order, each transferred exactly once, and each address advances by one after its transfer.
- R8: While `pm_valid` is high and `pm_ready` is low, `pm_addr`, `pm_data` and `pm_valid` hold, and SCK makes no edge.
- R9: Once word 255 is transferred, the address wraps to 0 and chip select rises. `run_start` then pulses high for exactly one cycle, and it does so only once per reset.
- R10: `busy` is high from reset until the cycle after `run_start` and low from then on. In modes 2'b00 and 2'b01 `busy` stays high, and there is no SCK edge, no write and no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_rw | input | 1 | Strap: high selects flash boot |
| strap_ck | input | 1 | Strap: with `strap_rw` low, picks external upload (high) or debug port (low) |
| spi_sck | output | 1 | SPI clock to the flash |
| spi_mosi | output | 1 | Serial command to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| pm_addr | output | 8 | Instruction-memory write address (program counter) |
| pm_data | output | 16 | Instruction word to write |
| pm_valid | output | 1 | Write request; holds until accepted |
| pm_ready | input | 1 | Memory accepts the word on this edge |
| boot_mode | output | 2 | Captured boot mode (encoding in R2) |
| busy | output | 1 | High until the program is started |
| run_start | output | 1 | One-cycle pulse: core may run from address 0 |

## Verification
The bench builds the loader with `SPI_DIV` = 4, which selects the counting variant of the clock divider and gives a half period of two cycles. That makes the SCK period and the MOSI setup before each rising edge measurable. The default 8-bit address and 16-bit word keep the full 256-word image, so each flash load ends through a real wrap of the address from 255 to 0. Two complete loads with different images run alongside both idle modes: one load stalls irregularly and once for twenty cycles, the other runs with no stalls at all.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    BOOT_TAP   = 2'b00,
    BOOT_SLAVE = 2'b01,
    BOOT_FLASH = 2'b10,
    BOOT_NONE  = 2'b11
  } boot_mode_e;

  typedef enum logic [2:0] {
    LD_WAIT,
    LD_CMD,
    LD_DATA,
    LD_PUSH,
    LD_START,
    LD_HOLD,
    LD_DONE
  } ld_state_e;

endpackage

// File: rtl/boot_strap_sample.sv
module boot_strap_sample
  import boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_rw,
  input  logic       strap_ck,
  output boot_mode_e mode_o,
  output logic       valid_o
);

  boot_mode_e mode_q;
  logic       taken_q;

  // One capture, on the first edge out of reset; frozen afterwards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= BOOT_NONE;
      taken_q <= 1'b0;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      if (strap_rw)      mode_q <= BOOT_FLASH;
      else if (strap_ck) mode_q <= BOOT_SLAVE;
      else               mode_q <= BOOT_TAP;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = taken_q;

endmodule

// File: rtl/boot_sck_gen.sv
module boot_sck_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;

  logic sck_q;
  logic edge_due;
  logic tick;

  generate
    if (HALF == 1) begin : g_fast
      assign edge_due = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(HALF);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= (cnt_q == CW'(HALF - 1)) ? '0 : cnt_q + 1'b1;
      end
      assign edge_due = (cnt_q == CW'(HALF - 1));
    end
  endgenerate

  assign tick = en && !clr && edge_due;

  // When en drops the phase is held, so a paused transfer resumes seamlessly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sck_q <= 1'b0;
    else if (clr)  sck_q <= 1'b0;
    else if (tick) sck_q <= ~sck_q;
  end

  assign sck_o  = sck_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;

endmodule

// File: rtl/boot_flash_loader.sv
module boot_flash_loader
  import boot_pkg::*;
#(
  parameter int         SPI_DIV = 4,
  parameter int         ADDR_W  = 8,
  parameter int         DATA_W  = 16,
  parameter int         CMD_W   = 32,
  parameter logic [7:0] READ_OP = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_rw,
  input  logic              strap_ck,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [DATA_W-1:0] pm_data,
  output logic              pm_valid,
  input  logic              pm_ready,
  output logic [1:0]        boot_mode,
  output logic              busy,
  output logic              run_start
);

  localparam int                BIT_W     = $clog2(CMD_W);
  localparam logic [CMD_W-1:0]  CMD_WORD  = {READ_OP, {(CMD_W - 8){1'b0}}};
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [BIT_W-1:0]  CMD_LAST  = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0]  WORD_LAST = BIT_W'(DATA_W - 1);

  boot_mode_e mode;
  logic       mode_valid;

  ld_state_e         state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              mosi_q;
  logic [DATA_W-1:0] word_q;
  logic [ADDR_W-1:0] addr_q;

  logic sck_en, sck_rise, sck_fall, cs_active;

  boot_strap_sample u_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strap_rw (strap_rw),
    .strap_ck (strap_ck),
    .mode_o   (mode),
    .valid_o  (mode_valid)
  );

  boot_sck_gen #(.DIV(SPI_DIV)) u_sck (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (sck_en),
    .clr    (!cs_active),
    .sck_o  (spi_sck),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  assign cs_active = (state_q == LD_CMD) || (state_q == LD_DATA) || (state_q == LD_PUSH);
  assign sck_en    = (state_q == LD_CMD) || (state_q == LD_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_WAIT;
      bit_q   <= '0;
      cmd_q   <= '0;
      mosi_q  <= 1'b0;
      word_q  <= '0;
      addr_q  <= '0;
    end else begin
      // Command bits leave on falling SCK; zeros follow the command.
      if (sck_fall) {mosi_q, cmd_q} <= {cmd_q, 1'b0};
      unique case (state_q)
        LD_WAIT: if (mode_valid) begin
          if (mode == BOOT_FLASH) begin
            state_q <= LD_CMD;
            mosi_q  <= CMD_WORD[CMD_W-1];
            cmd_q   <= CMD_WORD << 1;
            bit_q   <= '0;
          end else begin
            state_q <= LD_HOLD;
          end
        end
        LD_CMD: if (sck_rise) begin
          if (bit_q == CMD_LAST) begin
            bit_q   <= '0;
            state_q <= LD_DATA;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        LD_DATA: if (sck_rise) begin
          word_q <= {word_q[DATA_W-2:0], spi_miso};
          if (bit_q == WORD_LAST) begin
            bit_q   <= '0;
            state_q <= LD_PUSH;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        LD_PUSH: if (pm_ready) begin
          addr_q  <= addr_q + 1'b1;
          state_q <= (addr_q == LAST_ADDR) ? LD_START : LD_DATA;
        end
        LD_START: state_q <= LD_DONE;
        LD_HOLD:  state_q <= LD_HOLD;
        LD_DONE:  state_q <= LD_DONE;
        default:  state_q <= LD_HOLD;
      endcase
    end
  end

  assign spi_mosi  = mosi_q;
  assign spi_cs_n  = !cs_active;
  assign pm_addr   = addr_q;
  assign pm_data   = word_q;
  assign pm_valid  = (state_q == LD_PUSH);
  assign run_start = (state_q == LD_START);
  assign busy      = (state_q != LD_DONE);
  assign boot_mode = mode;

endmodule

// File: rtl/boot_flash_loader_chk.sv
module boot_flash_loader_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_sck,
  input logic              spi_cs_n,
  input logic [ADDR_W-1:0] pm_addr,
  input logic [DATA_W-1:0] pm_data,
  input logic              pm_valid,
  input logic              pm_ready,
  input logic              run_start,
  input logic              busy,
  input logic [1:0]        boot_mode
);

  assert_mode_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mode != 2'b11) |=> $stable(boot_mode));

  assert_cs_idle_modes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_mode == 2'b00 || boot_mode == 2'b01) |-> spi_cs_n);

  assert_no_write_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_valid |-> !spi_cs_n);

  assert_addr_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_valid && pm_ready) |=> (pm_addr == $past(pm_addr) + 1'b1));

  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_valid && !pm_ready) |=> (pm_valid && $stable(pm_addr) && $stable(pm_data)));

  assert_sck_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_valid && !pm_ready) |=> $stable(spi_sck));

  assert_single_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (!run_start && !busy));

  assert_start_flash_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> (boot_mode == 2'b10 && spi_cs_n));

  assert_idle_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (!busy && !run_start));

endmodule

bind boot_flash_loader boot_flash_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .pm_addr   (pm_addr),
  .pm_data   (pm_data),
  .pm_valid  (pm_valid),
  .pm_ready  (pm_ready),
  .run_start (run_start),
  .busy      (busy),
  .boot_mode (boot_mode)
);

// File: tb/boot_flash_loader_bench.sv
`timescale 1ns/1ps
module boot_flash_loader_bench;

  localparam int DIV = 4;
  localparam int WORDS = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_rw = 1'b0, strap_ck = 1'b0;
  logic spi_sck, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b0;
  logic [7:0] pm_addr;
  logic [15:0] pm_data;
  logic pm_valid;
  logic pm_ready = 1'b0;
  logic [1:0] boot_mode;
  logic busy, run_start;

  always #4 clk = ~clk;

  boot_flash_loader #(.SPI_DIV(DIV)) u_boot_flash_loader (
    .clk(clk), .rst_n(rst_n), .strap_rw(strap_rw), .strap_ck(strap_ck),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .pm_addr(pm_addr), .pm_data(pm_data), .pm_valid(pm_valid), .pm_ready(pm_ready),
    .boot_mode(boot_mode), .busy(busy), .run_start(run_start)
  );

  int checks = 0, errors = 0;
  int img_seed = 0;
  int ready_mode = 0;
  bit long_done = 0;
  int accepted = 0, starts = 0, accepted_at_start = -1;
  int sck_edges = 0, cs_falls = 0, mosi_bad = 0;
  logic [23:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] img_word(input int i, input int s);
    return {8'(i ^ s), 8'(i * 7 + s)};
  endfunction

  // Flash model: mode 0, shifts on falling SCK, captures on rising SCK.
  int rcnt = 0;
  logic [31:0] cmd_cap = '0;
  realtime t_r0 = 0, t_r1 = 0, t_mosi = 0;

  always @(negedge spi_cs_n) begin rcnt = 0; cs_falls++; end
  always @(spi_mosi) t_mosi = $realtime;
  always @(spi_sck) sck_edges++;
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if ($realtime - t_mosi < 4.0) mosi_bad++;
    if (rcnt == 0) t_r0 = $realtime;
    if (rcnt == 1) t_r1 = $realtime;
    if (rcnt < 32) cmd_cap = {cmd_cap[30:0], spi_mosi};
    rcnt++;
  end
  always @(negedge spi_sck) if (!spi_cs_n && rcnt >= 32) begin
    logic [15:0] w;
    w = img_word((rcnt - 32) / 16, img_seed);
    spi_miso = w[15 - ((rcnt - 32) % 16)];
  end

  // Ready driver, including one long stall at address 10.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      if (ready_mode == 1 && !long_done && pm_valid && pm_addr == 8'd10) begin
        logic [15:0] held;
        int snap;
        long_done = 1;
        pm_ready = 1'b0;
        held = pm_data;
        snap = sck_edges;
        repeat (20) @(posedge clk);
        #2;
        check(sck_edges == snap, "R8", "SCK edges during stall", sck_edges - snap, 0);
        check(pm_valid && pm_addr == 8'd10 && pm_data == held, "R8", "word held",
              {pm_valid, pm_addr, pm_data}, {1'b1, 8'd10, held});
        pm_ready = 1'b1;
      end else begin
        pm_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (cyc % 3 != 0) : 1'b0;
      end
    end
  end

  // Scoreboard monitor.
  initial begin
    bit prev_start = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pm_valid && pm_ready) begin
          if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected write", {pm_addr, pm_data}, 0);
          end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            check({pm_addr, pm_data} == e, "R6 R7", "word/address", {pm_addr, pm_data}, e);
          end
          accepted++;
        end
        if (prev_start)
          check(!busy && !run_start, "R10", "busy/start after pulse", {busy, run_start}, 0);
        if (run_start) begin
          starts++;
          accepted_at_start = accepted;
          check(busy, "R10", "busy during pulse", busy, 1);
        end
        prev_start = run_start;
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R9", "watchdog expired", 0, 1);
    summary();
  end

  task automatic do_reset(input logic rw, input logic ck);
    #2 rst_n = 1'b0;
    strap_rw = rw; strap_ck = ck;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(boot_mode == 2'b11, "R2", "mode in reset", boot_mode, 2'b11);
    check(spi_cs_n && !spi_sck, "R3", "cs/sck in reset", {spi_cs_n, spi_sck}, 2'b10);
    check(busy && !run_start && !pm_valid, "R10", "busy/start/valid in reset",
          {busy, run_start, pm_valid}, 3'b100);
    accepted = 0; starts = 0; accepted_at_start = -1; long_done = 0;
    cs_falls = 0; mosi_bad = 0; cmd_cap = '0;
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic run_idle(input logic rw, input logic ck, input logic [1:0] m);
    int snap;
    ready_mode = 2;
    do_reset(rw, ck);
    check(boot_mode == m, "R2", "decoded mode", boot_mode, m);
    snap = sck_edges;
    strap_rw = ~rw; strap_ck = ~ck;
    repeat (300) @(posedge clk);
    #2;
    check(boot_mode == m, "R1", "mode after strap change", boot_mode, m);
    check(cs_falls == 0 && spi_cs_n, "R3", "cs never asserted", cs_falls, 0);
    check(sck_edges == snap && accepted == 0 && starts == 0, "R10", "idle activity",
          {sck_edges - snap, accepted, starts}, 0);
    check(busy, "R10", "busy held in idle mode", busy, 1);
  endtask

  task automatic run_flash(input int sd, input int rm);
    int guard = 0;
    img_seed = sd;
    ready_mode = rm;
    for (int i = 0; i < WORDS; i++) exp_q.push_back({8'(i), img_word(i, sd)});
    do_reset(1'b1, 1'b0);
    check(boot_mode == 2'b10, "R2", "flash mode", boot_mode, 2'b10);
    strap_rw = 1'b0; strap_ck = 1'b0;
    while (starts == 0 && guard < 60000) begin @(posedge clk); guard++; end
    repeat (5) @(posedge clk);
    #2;
    check(boot_mode == 2'b10, "R1", "mode kept after strap change", boot_mode, 2'b10);
    check(cmd_cap == 32'h0300_0000, "R4", "read command", cmd_cap, 32'h0300_0000);
    check(mosi_bad == 0, "R4", "MOSI change near rising SCK", mosi_bad, 0);
    check(t_r1 - t_r0 == DIV * 8.0, "R5", "SCK period ns", longint'(t_r1 - t_r0), DIV * 8);
    check(exp_q.size() == 0 && accepted == WORDS, "R7", "all words written",
          accepted, WORDS);
    check(starts == 1 && accepted_at_start == WORDS, "R9", "start after last word",
          {starts, accepted_at_start}, {1, WORDS});
    check(pm_addr == 8'd0 && spi_cs_n && !spi_sck, "R9", "address wrap and deselect",
          {pm_addr, spi_cs_n, spi_sck}, 10'b0000_0000_10);
    check(cs_falls == 1, "R3", "single select window", cs_falls, 1);
    check(!busy && !pm_valid, "R10", "busy low after start", {busy, pm_valid}, 0);
    if (rm == 1) check(long_done, "R8", "long stall exercised", long_done, 1);
    repeat (100) @(posedge clk);
    #2;
    check(starts == 1 && !busy, "R9", "no second start", starts, 1);
    exp_q.delete();
  endtask

  initial begin
    run_idle(1'b0, 1'b0, 2'b00);
    run_idle(1'b0, 1'b1, 2'b01);
    run_flash(8'h3C, 1);
    run_flash(8'hA1, 0);
    summary();
  end

endmodule